// File: doc/BRIEF.md
# Hot-Plug Power Fault Reporter

This block collects the per-slot power fault bits that an input scan engine delivers and reports them in two ways. It holds a status vector that software reads. That vector shows either the raw bits of the most recent scan, sticky latched copies of them, or a forced all-ones value. It also raises a one-cycle system error pulse when a latched fault appears on a slot that is far enough into power-up while every error enable is on. The scan engine appears as a byte-wide strobe plus an end-of-scan pulse. Slot sequencing is outside the block except for one phase input per slot and an update strobe.

A 16-bit configuration register sits beside this logic. It has read/write enables, fixed read-only bits, a scan-complete flag that software sets and hardware clears, and a busy flag. A three-state machine drives the busy flag. WAIT_WR is entered at reset with busy set. It moves to WAIT_UPD on the first configuration write. WAIT_UPD moves to IDLE when the sequencer reports that the slot controls were updated, and busy clears there. IDLE is terminal until reset.

Register layout: bit 15 reads 0, bit 14 is the error-on-fault enable, bit 13 is the latch-view select, bit 12 is scan-complete, bit 11 reads 1 (66 MHz clock), bit 10 is the master fault enable, bit 9 is the auto power-off disable (stored only), bit 8 is busy, and bits 7:0 read 0.

Top module: `hp_fault_report`

## Requirements
- R1: After reset, cfg_rd_data reads 0x0900, flt_status reads all zeros and serr_pulse is 0.
- R2: A write stores bits 14, 13, 10 and 9. Bits 15 and 7:0 always read 0, bit 11 always reads 1, and bit 8 ignores written data.
- R3: Writing 1 to bit 12 sets it, and writing 0 leaves it unchanged. A scan_done pulse clears it. When a set and a clear arrive in the same cycle, the set wins.
- R4: Bit 8 (busy) is 1 from reset until a ctl_update pulse follows the first configuration write. A ctl_update pulse before any write has no effect. Once clear, busy stays 0 until reset.
- R5: With bit 13 at 0, flt_status equals the fault bits of the most recent scan strobe.
- R6: A slot's fault latch sets when its scanned bit is 1 and bit 10 is 1. It does not set while bit 10 is 0. It clears only on a clear write with a 1 in that slot's position. A set in the same cycle as a clear wins.
- R7: With bit 13 at 1 and bit 10 at 1, flt_status equals the fault latches.
- R8: With bit 13 at 1 and bit 10 at 0, flt_status reads all ones, whatever is scanned.
- R9: A slot qualifies when its latch is set, its slot_past_clk bit is 1, bits 14 and 10 are both 1, and cmd_serr_en is 1. serr_pulse never rises unless all of these hold for some slot.
- R10: serr_pulse is high for one cycle, starting the clock after any slot newly qualifies. A slot that stays qualified does not raise it again. A second slot that qualifies later raises a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 16 | Configuration write data |
| cfg_rd_data | output | 16 | Configuration register read value |
| scan_vld | input | 1 | Scanned fault bits valid |
| scan_bits | input | NUM_SLOTS | Scanned fault bits, one per slot |
| scan_done | input | 1 | End of a complete input scan |
| flt_clr_wr | input | 1 | Fault latch clear strobe |
| flt_clr_bits | input | NUM_SLOTS | Write-1-to-clear mask for the latches |
| flt_status | output | NUM_SLOTS | Fault status vector |
| cmd_serr_en | input | 1 | System error enable from the command register |
| slot_past_clk | input | NUM_SLOTS | Slot is powered or past clock connect |
| ctl_update | input | 1 | Slot controls were updated by the sequencer |
| serr_pulse | output | 1 | System error pulse |

## Verification
Register and latch results (cfg_rd_data, flt_status) appear one clock after the strobe that causes them. The bench therefore drives a strobe for exactly one edge and samples shortly after that edge. serr_pulse lags one more register. It is checked low right after the edge that sets a latch or raises an enable, high after the next edge, and low again after the edge after that, which proves it does not repeat. All sixteen combinations of the four gating conditions are walked this way.

// File: rtl/hp_fault_pkg.sv
package hp_fault_pkg;
    localparam int CFG_W        = 16;
    localparam int B_ERR_ON_FLT = 14;
    localparam int B_LATCH_VIEW = 13;
    localparam int B_SCAN_FRESH = 12;
    localparam int B_CLK66      = 11;
    localparam int B_FLT_MASTER = 10;
    localparam int B_AUTO_OFF   = 9;
    localparam int B_BUSY       = 8;

    typedef enum logic [1:0] {
        BSY_WAIT_WR  = 2'd0,
        BSY_WAIT_UPD = 2'd1,
        BSY_IDLE     = 2'd2
    } busy_state_t;
endpackage

// File: rtl/hp_cfg_reg.sv
module hp_cfg_reg
    import hp_fault_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             scan_done,
    input  logic             ctl_update,
    output logic [CFG_W-1:0] cfg_q,
    output logic             err_on_fault,
    output logic             latch_view,
    output logic             fault_master
);
    busy_state_t state_q, state_d;
    logic        busy;
    logic        auto_off_q;
    logic        scan_fresh_q;
    logic        unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[15], wr_data[B_CLK66], wr_data[B_BUSY], wr_data[7:0]};

    // Busy state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BSY_WAIT_WR;
        else        state_q <= state_d;
    end

    // Busy next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BSY_WAIT_WR:  if (wr_en)      state_d = BSY_WAIT_UPD;
            BSY_WAIT_UPD: if (ctl_update) state_d = BSY_IDLE;
            BSY_IDLE:                     state_d = BSY_IDLE;
            default:                      state_d = BSY_WAIT_WR;
        endcase
    end

    // Busy output decode
    always_comb begin
        unique case (state_q)
            BSY_IDLE: busy = 1'b0;
            default:  busy = 1'b1;
        endcase
    end

    // Writable bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_on_fault <= 1'b0;
            latch_view   <= 1'b0;
            fault_master <= 1'b0;
            auto_off_q   <= 1'b0;
        end else if (wr_en) begin
            err_on_fault <= wr_data[B_ERR_ON_FLT];
            latch_view   <= wr_data[B_LATCH_VIEW];
            fault_master <= wr_data[B_FLT_MASTER];
            auto_off_q   <= wr_data[B_AUTO_OFF];
        end
    end

    // Scan-complete flag: software set wins over hardware clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               scan_fresh_q <= 1'b0;
        else if (wr_en && wr_data[B_SCAN_FRESH])  scan_fresh_q <= 1'b1;
        else if (scan_done)                       scan_fresh_q <= 1'b0;
    end

    always_comb begin
        cfg_q               = '0;
        cfg_q[B_ERR_ON_FLT] = err_on_fault;
        cfg_q[B_LATCH_VIEW] = latch_view;
        cfg_q[B_SCAN_FRESH] = scan_fresh_q;
        cfg_q[B_CLK66]      = 1'b1;
        cfg_q[B_FLT_MASTER] = fault_master;
        cfg_q[B_AUTO_OFF]   = auto_off_q;
        cfg_q[B_BUSY]       = busy;
    end

    // R4
    busy_norise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(busy));
    // R4
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(ctl_update));
    // R3
    scan_fresh_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_fresh_q) |-> $past(scan_done));
endmodule

// File: rtl/hp_fault_latch.sv
module hp_fault_latch #(
    parameter int NUM_SLOTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_vld,
    input  logic [NUM_SLOTS-1:0] scan_bits,
    input  logic                 clr_wr,
    input  logic [NUM_SLOTS-1:0] clr_bits,
    input  logic                 fault_master,
    input  logic                 latch_view,
    output logic [NUM_SLOTS-1:0] latch_q,
    output logic [NUM_SLOTS-1:0] status
);
    logic [NUM_SLOTS-1:0] raw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        raw_q <= '0;
        else if (scan_vld) raw_q <= scan_bits;
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic set_i, clr_i;
        assign set_i = scan_vld && scan_bits[i] && fault_master;
        assign clr_i = clr_wr && clr_bits[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     latch_q[i] <= 1'b0;
            else if (set_i) latch_q[i] <= 1'b1;
            else if (clr_i) latch_q[i] <= 1'b0;
        end

        // R6
        latch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(latch_q[i]) |-> $past(clr_wr && clr_bits[i]));
    end

    always_comb begin
        if (!latch_view)       status = raw_q;
        else if (fault_master) status = latch_q;
        else                   status = '1;
    end
endmodule

// File: rtl/hp_serr_gen.sv
module hp_serr_gen #(
    parameter int NUM_SLOTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] latch_q,
    input  logic [NUM_SLOTS-1:0] slot_phase,
    input  logic                 err_on_fault,
    input  logic                 fault_master,
    input  logic                 cmd_serr_en,
    output logic                 serr
);
    logic                 gate_on;
    logic [NUM_SLOTS-1:0] qual, qual_q;

    assign gate_on = err_on_fault && fault_master && cmd_serr_en;
    assign qual    = gate_on ? (latch_q & slot_phase) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_q <= '0;
            serr   <= 1'b0;
        end else begin
            qual_q <= qual;
            serr   <= |(qual & ~qual_q);
        end
    end

    // R9
    serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr |-> $past(err_on_fault && fault_master && cmd_serr_en));
    // R10
    serr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr |-> $past(|(latch_q & slot_phase)));
endmodule

// File: rtl/hp_fault_report.sv
module hp_fault_report
    import hp_fault_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic [15:0]          cfg_wr_data,
    output logic [15:0]          cfg_rd_data,
    input  logic                 scan_vld,
    input  logic [NUM_SLOTS-1:0] scan_bits,
    input  logic                 scan_done,
    input  logic                 flt_clr_wr,
    input  logic [NUM_SLOTS-1:0] flt_clr_bits,
    output logic [NUM_SLOTS-1:0] flt_status,
    input  logic                 cmd_serr_en,
    input  logic [NUM_SLOTS-1:0] slot_past_clk,
    input  logic                 ctl_update,
    output logic                 serr_pulse
);
    logic                 err_on_fault, latch_view, fault_master;
    logic [NUM_SLOTS-1:0] latch_q;

    hp_cfg_reg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cfg_wr_en),
        .wr_data      (cfg_wr_data),
        .scan_done    (scan_done),
        .ctl_update   (ctl_update),
        .cfg_q        (cfg_rd_data),
        .err_on_fault (err_on_fault),
        .latch_view   (latch_view),
        .fault_master (fault_master)
    );

    hp_fault_latch #(.NUM_SLOTS(NUM_SLOTS)) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .scan_vld     (scan_vld),
        .scan_bits    (scan_bits),
        .clr_wr       (flt_clr_wr),
        .clr_bits     (flt_clr_bits),
        .fault_master (fault_master),
        .latch_view   (latch_view),
        .latch_q      (latch_q),
        .status       (flt_status)
    );

    hp_serr_gen #(.NUM_SLOTS(NUM_SLOTS)) u_serr (
        .clk          (clk),
        .rst_n        (rst_n),
        .latch_q      (latch_q),
        .slot_phase   (slot_past_clk),
        .err_on_fault (err_on_fault),
        .fault_master (fault_master),
        .cmd_serr_en  (cmd_serr_en),
        .serr         (serr_pulse)
    );

    // R8
    status_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data[B_LATCH_VIEW] && !cfg_rd_data[B_FLT_MASTER]) |-> (flt_status == '1));
endmodule

// File: tb/tb_hp_fault_report.sv
module tb_hp_fault_report;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr_en = 1'b0;
    logic [15:0]  cfg_wr_data = '0;
    logic [15:0]  cfg_rd_data;
    logic         scan_vld = 1'b0;
    logic [N-1:0] scan_bits = '0;
    logic         scan_done = 1'b0;
    logic         flt_clr_wr = 1'b0;
    logic [N-1:0] flt_clr_bits = '0;
    logic [N-1:0] flt_status;
    logic         cmd_serr_en = 1'b0;
    logic [N-1:0] slot_past_clk = '0;
    logic         ctl_update = 1'b0;
    logic         serr_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hp_fault_report #(.NUM_SLOTS(N)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .scan_vld(scan_vld), .scan_bits(scan_bits),
        .scan_done(scan_done), .flt_clr_wr(flt_clr_wr), .flt_clr_bits(flt_clr_bits),
        .flt_status(flt_status), .cmd_serr_en(cmd_serr_en), .slot_past_clk(slot_past_clk),
        .ctl_update(ctl_update), .serr_pulse(serr_pulse)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [15:0] d);
        cfg_wr_en = 1'b1; cfg_wr_data = d; tick(); cfg_wr_en = 1'b0;
    endtask

    task automatic scan(logic [N-1:0] b);
        scan_vld = 1'b1; scan_bits = b; tick(); scan_vld = 1'b0;
    endtask

    task automatic clr(logic [N-1:0] m);
        flt_clr_wr = 1'b1; flt_clr_bits = m; tick(); flt_clr_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cfg", cfg_rd_data, 16'h0900);
        chk("R1 status", 16'(flt_status), 16'h0000);
        chk("R1 serr", 16'(serr_pulse), 16'h0000);
    endtask

    task automatic t_busy();
        ctl_update = 1'b1; tick(); ctl_update = 1'b0;
        chk("R4 early update", cfg_rd_data, 16'h0900);
        cfg_write(16'h0000);
        chk("R4 after write", cfg_rd_data, 16'h0900);
        ctl_update = 1'b1; tick(); ctl_update = 1'b0;
        chk("R4 cleared", cfg_rd_data, 16'h0800);
        cfg_write(16'h0000);
        chk("R4 stays clear", cfg_rd_data, 16'h0800);
    endtask

    task automatic t_rw();
        cfg_write(16'hFFFF);
        chk("R2 all ones", cfg_rd_data, 16'h7E00);
        cfg_write(16'h0000);
        chk("R3 write0 keeps", cfg_rd_data, 16'h1800);
        scan_done = 1'b1; tick(); scan_done = 1'b0;
        chk("R3 hw clear", cfg_rd_data, 16'h0800);
        scan_done = 1'b1; cfg_write(16'h1000); scan_done = 1'b0;
        chk("R3 set wins", cfg_rd_data, 16'h1800);
        scan_done = 1'b1; tick(); scan_done = 1'b0;
        chk("R3 clear again", cfg_rd_data, 16'h0800);
    endtask

    task automatic t_raw();
        cfg_write(16'h0000);
        scan(8'hA5);
        chk("R5 raw A5", 16'(flt_status), 16'h00A5);
        scan(8'h3C);
        chk("R5 raw 3C", 16'(flt_status), 16'h003C);
        cfg_write(16'h2400);
        chk("R6 no latch when master off", 16'(flt_status), 16'h0000);
    endtask

    task automatic t_latch();
        scan(8'h05);
        chk("R7 latch view", 16'(flt_status), 16'h0005);
        scan(8'h00);
        chk("R6 sticky", 16'(flt_status), 16'h0005);
        scan(8'h80);
        chk("R6 accumulate", 16'(flt_status), 16'h0085);
        clr(8'h01);
        chk("R6 w1c", 16'(flt_status), 16'h0084);
        flt_clr_wr = 1'b1; flt_clr_bits = 8'h04; scan(8'h04); flt_clr_wr = 1'b0;
        chk("R6 set wins", 16'(flt_status), 16'h0084);
        clr(8'hFF);
        chk("R6 clear all", 16'(flt_status), 16'h0000);
        cfg_write(16'h0400);
        chk("R5 raw after latch", 16'(flt_status), 16'h0004);
    endtask

    task automatic t_force();
        cfg_write(16'h2000);
        chk("R8 forced", 16'(flt_status), 16'h00FF);
        scan(8'h12);
        chk("R8 forced scan", 16'(flt_status), 16'h00FF);
        cfg_write(16'h0000);
        chk("R5 raw restore", 16'(flt_status), 16'h0012);
    endtask

    task automatic t_gate();
        for (int c = 0; c < 16; c++) begin
            logic e, p, m, ph, ex;
            e = c[0]; p = c[1]; m = c[2]; ph = c[3];
            ex = e & p & m & ph;
            cmd_serr_en = 1'b0; slot_past_clk = '0;
            cfg_write(16'h0000);
            clr(8'hFF);
            tick();
            cfg_write({1'b0, e, 3'b000, p, 10'b0});
            cmd_serr_en = m; slot_past_clk = {7'b0, ph};
            tick();
            chk("R9 idle", 16'(serr_pulse), 16'h0000);
            scan(8'h01);
            chk("R10 latency", 16'(serr_pulse), 16'h0000);
            tick();
            chk("R9 gate combo", 16'(serr_pulse), 16'(ex));
            tick();
            chk("R10 single pulse", 16'(serr_pulse), 16'h0000);
        end
    endtask

    task automatic t_multi();
        cmd_serr_en = 1'b1; slot_past_clk = 8'hFF;
        clr(8'hFF);
        cfg_write(16'h4400);
        tick();
        scan(8'h01); tick();
        chk("R10 first slot", 16'(serr_pulse), 16'h0001);
        tick();
        chk("R10 pulse ends", 16'(serr_pulse), 16'h0000);
        scan(8'h03); tick();
        chk("R10 second slot", 16'(serr_pulse), 16'h0001);
        scan(8'h03); tick();
        chk("R10 persistent", 16'(serr_pulse), 16'h0000);
        clr(8'hFF); tick();
        slot_past_clk = 8'h01;
        scan(8'h04); tick();
        chk("R9 phase gate", 16'(serr_pulse), 16'h0000);
        slot_past_clk = 8'h05;
        tick();
        chk("R9 phase reached", 16'(serr_pulse), 16'h0001);
        tick();
        chk("R10 phase pulse ends", 16'(serr_pulse), 16'h0000);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_busy();
        t_rw();
        t_raw();
        t_latch();
        t_force();
        t_gate();
        t_multi();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule